// File: doc/BRIEF.md
# Event-Triggered Converter Programming Sequencer

This block programs an external voltage converter over a two-wire I2C bus without any processor in the loop. It sits next to a USB-C power-delivery state machine and receives one-cycle strobes from it. The strobes are: power-on initialisation, one of four source-profile contracts negotiated, and cable detach. Each strobe selects a short, fixed list of register writes from an internal table. The block then runs those writes, in order, as I2C write frames to a single 7-bit target address.

Strobes that arrive while a list is running are remembered in a pending mask and served later by fixed priority. The bus side is an open-drain master. It only ever pulls SCL and SDA low, and it takes the acknowledge level back from the SDA line. A NACK on any byte ends the current list and sets an error flag that stays set until reset. A `busy` level and a one-cycle `done` pulse tell the surrounding logic when the converter has been reprogrammed.

Top module: `evt_i2c_seq`

## Requirements
- R1: After reset is released, the block runs the boot list with no strobe needed, and a later `ev_por` strobe runs it again. The boot list is three one-byte writes in this order: register 0x00 gets 0xD2, then register 0x04 gets 0x03, then register 0x06 gets 0xA0. While reset is held, `busy`, `nack_err`, `scl_oe` and `sda_oe` are all 0.
- R2: A strobe on `ev_contract[k]` runs one two-byte write to register 0x00: the low byte of that profile's 16-bit reference code, then the high byte. The default codes are 0x00D2, 0x0199, 0x02C5 and 0x03BE for k = 0, 1, 2 and 3.
- R3: A strobe on `ev_detach` runs one two-byte write to register 0x00 with data 0xD2 then 0x00, so the converter's auto-increment puts the high byte in register 0x01.
- R4: Every frame is START, the address byte `{DEV_ADDR,0}` (0xE8 for the default 0x74), the register pointer, the data bytes, then STOP. Both line enables are 0 whenever `busy` is 0.
- R5: When several events are requested at once, they are served in this order: power-on first, then detach, then contract 0 to contract 3.
- R6: On a NACK of any byte, the master ends the frame with STOP and the rest of that list is dropped. `nack_err` goes to 1 and stays at 1 until reset, `done` does not pulse, and the next pending event is served.
- R7: If the block is idle, `busy` is 1 from the clock edge that samples a strobe. `done` is a single-cycle pulse on the edge where `busy` returns to 0 after a list whose every byte was acknowledged.
- R8: SDA changes only while SCL is low, except for the START and STOP conditions. SCL and SDA never change in the same cycle. The SCL period is 4*QUARTER clock cycles.
- R9: Register 0x03 is never used as a register pointer, so the converter's slew setting stays at its default.
- R10: Repeating a strobe for an event that is already pending does not add another run of that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_por | input | 1 | Strobe: run the boot list |
| ev_contract | input | 4 | Strobes: source profile k negotiated |
| ev_detach | input | 1 | Strobe: sink detached |
| sda_i | input | 1 | Level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | A list is being run |
| done | output | 1 | One-cycle pulse when a list completes with all bytes acknowledged |
| nack_err | output | 1 | Sticky NACK flag |

## Verification
A strobe that reaches an idle block shows up as `busy` one clock edge later. The bench drives each strobe on a falling edge and reads `busy` on the next falling edge, which is just after that rising edge. Bus results take much longer and their length depends on the frame. For those, the bench waits until `busy` has been low for four falling edges in a row; the gap between queued lists is a single cycle, so this wait cannot end between two lists. It then compares the frames that its bus model captured, and their count, against lists built from the event numbers. The SCL period is measured in clock cycles between rising SCL edges inside a byte.

// File: rtl/evtseq_pkg.sv
package evtseq_pkg;

    localparam int NUM_EV       = 6;
    localparam int NUM_CONTRACT = 4;
    localparam int TABLE_DEPTH  = 9;
    localparam int IDX_W        = $clog2(TABLE_DEPTH);
    localparam int STEP_W       = 2;
    localparam int FRAME_BYTES  = 4;
    localparam int LEN_W        = 3;

    // event bit positions; lower bit means higher priority
    localparam logic [2:0] EV_POR       = 3'd0;
    localparam logic [2:0] EV_DETACH    = 3'd1;
    localparam logic [2:0] EV_CONTRACT0 = 3'd2;

    // slot layout of the write table
    localparam int BOOT_BASE     = 0;
    localparam int BOOT_STEPS    = 3;
    localparam int CONTRACT_BASE = BOOT_BASE + BOOT_STEPS;
    localparam int DETACH_SLOT   = CONTRACT_BASE + NUM_CONTRACT;
    localparam int SPARE_SLOT    = DETACH_SLOT + 1;

    // converter register map used by the lists
    localparam logic [7:0] REG_REF_LO   = 8'h00;
    localparam logic [7:0] REG_SLEW     = 8'h03;
    localparam logic [7:0] REG_FEEDBACK = 8'h04;
    localparam logic [7:0] REG_MODE     = 8'h06;

    localparam logic [7:0] BOOT_REF  = 8'hD2;
    localparam logic [7:0] BOOT_FB   = 8'h03;
    localparam logic [7:0] BOOT_MODE = 8'hA0;

    typedef struct packed {
        logic [7:0] ptr;
        logic       wide;
        logic [7:0] lo;
        logic [7:0] hi;
    } wr_entry_t;

    typedef struct packed {
        logic [FRAME_BYTES-1:0][7:0] bytes;
        logic [LEN_W-1:0]            len;
    } i2c_frame_t;

    typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} seq_state_e;

    typedef enum logic [2:0] {BM_IDLE, BM_START, BM_BIT, BM_ACK, BM_STOP} bus_state_e;

    function automatic logic [NUM_EV-1:0] lowest_set(input logic [NUM_EV-1:0] v);
        logic [NUM_EV-1:0] r;
        r = '0;
        for (int i = NUM_EV - 1; i >= 0; i--) begin
            if (v[i]) r = NUM_EV'(1) << i;
        end
        return r;
    endfunction

    function automatic logic [2:0] onehot_to_ev(input logic [NUM_EV-1:0] oh);
        logic [2:0] r;
        r = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            if (oh[i]) r = 3'(i);
        end
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] ev_base(input logic [2:0] ev);
        if (ev == EV_POR)    return IDX_W'(BOOT_BASE);
        if (ev == EV_DETACH) return IDX_W'(DETACH_SLOT);
        return IDX_W'(CONTRACT_BASE) + IDX_W'(ev - EV_CONTRACT0);
    endfunction

    function automatic logic [STEP_W-1:0] ev_last_step(input logic [2:0] ev);
        return (ev == EV_POR) ? STEP_W'(BOOT_STEPS - 1) : '0;
    endfunction

    function automatic i2c_frame_t make_frame(input logic [6:0] addr, input wr_entry_t e);
        i2c_frame_t f;
        f.bytes[0] = {addr, 1'b0};
        f.bytes[1] = e.ptr;
        f.bytes[2] = e.lo;
        f.bytes[3] = e.hi;
        f.len      = e.wide ? LEN_W'(4) : LEN_W'(3);
        return f;
    endfunction

endpackage

// File: rtl/evtseq_table.sv
module evtseq_table
    import evtseq_pkg::*;
#(
    parameter logic [15:0] REF_5V  = 16'h00D2,
    parameter logic [15:0] REF_9V  = 16'h0199,
    parameter logic [15:0] REF_15V = 16'h02C5,
    parameter logic [15:0] REF_20V = 16'h03BE
) (
    input  logic [IDX_W-1:0] idx,
    output wr_entry_t        entry
);

    localparam logic [NUM_CONTRACT-1:0][15:0] REFS = {REF_20V, REF_15V, REF_9V, REF_5V};

    wr_entry_t slots [TABLE_DEPTH];

    assign slots[BOOT_BASE]     = '{ptr: REG_REF_LO,   wide: 1'b0, lo: BOOT_REF,  hi: 8'h00};
    assign slots[BOOT_BASE + 1] = '{ptr: REG_FEEDBACK, wide: 1'b0, lo: BOOT_FB,   hi: 8'h00};
    assign slots[BOOT_BASE + 2] = '{ptr: REG_MODE,     wide: 1'b0, lo: BOOT_MODE, hi: 8'h00};

    for (genvar k = 0; k < NUM_CONTRACT; k++) begin : g_contract
        assign slots[CONTRACT_BASE + k] = '{ptr: REG_REF_LO, wide: 1'b1,
                                            lo: REFS[k][7:0], hi: REFS[k][15:8]};
    end

    // detach: full 16-bit reference back to the 5 V code
    assign slots[DETACH_SLOT] = '{ptr: REG_REF_LO, wide: 1'b1, lo: BOOT_REF, hi: 8'h00};
    assign slots[SPARE_SLOT]  = '0;

    always_comb begin
        entry = '0;
        for (int i = 0; i < TABLE_DEPTH; i++) begin
            if (idx == IDX_W'(i)) entry = slots[i];
        end
    end

endmodule

// File: rtl/evtseq_pending.sv
module evtseq_pending
    import evtseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] ev_in,
    input  logic              take,
    output logic [NUM_EV-1:0] grant
);

    logic [NUM_EV-1:0] pend;
    logic [NUM_EV-1:0] req;

    assign req   = pend | ev_in;
    assign grant = take ? lowest_set(req) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            // boot list is owed from reset onward
            pend <= NUM_EV'(1) << EV_POR;
        end else begin
            pend <= req & ~grant;
        end
    end

endmodule

// File: rtl/evtseq_i2c_master.sv
module evtseq_i2c_master
    import evtseq_pkg::*;
#(
    parameter int QUARTER = 125
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  i2c_frame_t frame,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       done,
    output logic       nack,
    output logic       in_cond
);

    localparam int DIV_W = (QUARTER > 1) ? $clog2(QUARTER) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(QUARTER - 1);

    bus_state_e                  state;
    logic [1:0]                  q;
    logic [DIV_W-1:0]            div;
    logic [1:0]                  bidx;
    logic [2:0]                  bit_i;
    logic [FRAME_BYTES-1:0][7:0] bytes;
    logic [LEN_W-1:0]            len;
    logic                        scl_low, sda_low;
    logic                        done_r, nack_r;
    logic                        sda_meta, sda_sync;
    logic                        tick, cur_bit, last_byte;

    assign tick      = (div == DIV_LAST);
    assign cur_bit   = bytes[bidx][bit_i];
    assign last_byte = ({1'b0, bidx} == len - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_meta <= 1'b1;
            sda_sync <= 1'b1;
        end else begin
            sda_meta <= sda_i;
            sda_sync <= sda_meta;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= BM_IDLE;
            q       <= '0;
            div     <= '0;
            bidx    <= '0;
            bit_i   <= '0;
            bytes   <= '0;
            len     <= '0;
            scl_low <= 1'b0;
            sda_low <= 1'b0;
            done_r  <= 1'b0;
            nack_r  <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (state == BM_IDLE) begin
                div <= '0;
                q   <= '0;
                if (go) begin
                    bytes  <= frame.bytes;
                    len    <= frame.len;
                    nack_r <= 1'b0;
                    state  <= BM_START;
                end
            end else begin
                div <= tick ? '0 : div + DIV_W'(1);
                if (tick) begin
                    q <= q + 2'd1;
                    unique case (state)
                        BM_START: begin
                            if (q == 2'd0) sda_low <= 1'b1;
                            if (q == 2'd1) begin
                                scl_low <= 1'b1;
                                state   <= BM_BIT;
                                q       <= '0;
                                bidx    <= '0;
                                bit_i   <= 3'd7;
                            end
                        end
                        BM_BIT: begin
                            if (q == 2'd0) sda_low <= ~cur_bit;
                            if (q == 2'd1) scl_low <= 1'b0;
                            if (q == 2'd3) begin
                                scl_low <= 1'b1;
                                if (bit_i == 3'd0) state <= BM_ACK;
                                else bit_i <= bit_i - 3'd1;
                            end
                        end
                        BM_ACK: begin
                            if (q == 2'd0) sda_low <= 1'b0;
                            if (q == 2'd1) scl_low <= 1'b0;
                            if (q == 2'd2 && sda_sync) nack_r <= 1'b1;
                            if (q == 2'd3) begin
                                scl_low <= 1'b1;
                                if (nack_r || last_byte) begin
                                    state <= BM_STOP;
                                end else begin
                                    bidx  <= bidx + 2'd1;
                                    bit_i <= 3'd7;
                                    state <= BM_BIT;
                                end
                            end
                        end
                        BM_STOP: begin
                            if (q == 2'd0) sda_low <= 1'b1;
                            if (q == 2'd1) scl_low <= 1'b0;
                            if (q == 2'd2) sda_low <= 1'b0;
                            if (q == 2'd3) begin
                                done_r <= 1'b1;
                                state  <= BM_IDLE;
                            end
                        end
                        default: state <= BM_IDLE;
                    endcase
                end
            end
        end
    end

    assign scl_oe  = scl_low;
    assign sda_oe  = sda_low;
    assign done    = done_r;
    assign nack    = nack_r;
    assign in_cond = (state == BM_START) || (state == BM_STOP);

endmodule

// File: rtl/evt_i2c_seq.sv
module evt_i2c_seq
    import evtseq_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h74,
    parameter int          QUARTER  = 125,
    parameter logic [15:0] REF_9V   = 16'h0199,
    parameter logic [15:0] REF_15V  = 16'h02C5,
    parameter logic [15:0] REF_20V  = 16'h03BE
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ev_por,
    input  logic [NUM_CONTRACT-1:0] ev_contract,
    input  logic                    ev_detach,
    input  logic                    sda_i,
    output logic                    scl_oe,
    output logic                    sda_oe,
    output logic                    busy,
    output logic                    done,
    output logic                    nack_err
);

    localparam logic [15:0] REF_5V = {8'h00, BOOT_REF};

    seq_state_e         state;
    logic [IDX_W-1:0]   base;
    logic [STEP_W-1:0]  step, last;
    logic               done_r, err_r;
    logic [NUM_EV-1:0]  ev_vec, grant;
    logic [2:0]         ev_sel;
    logic [IDX_W-1:0]   slot_idx;
    wr_entry_t          entry;
    i2c_frame_t         m_frame;
    logic               m_go, m_done, m_nack, m_in_cond;
    logic [7:0]         frame_ptr;

    assign ev_vec = {ev_contract, ev_detach, ev_por};

    evtseq_pending u_pending (
        .clk   (clk),
        .rst   (rst),
        .ev_in (ev_vec),
        .take  (state == SQ_IDLE),
        .grant (grant)
    );

    assign ev_sel   = onehot_to_ev(grant);
    assign slot_idx = base + IDX_W'(step);

    evtseq_table #(
        .REF_5V  (REF_5V),
        .REF_9V  (REF_9V),
        .REF_15V (REF_15V),
        .REF_20V (REF_20V)
    ) u_table (
        .idx   (slot_idx),
        .entry (entry)
    );

    assign m_frame   = make_frame(DEV_ADDR, entry);
    assign frame_ptr = m_frame.bytes[1];
    assign m_go      = (state == SQ_ISSUE);

    evtseq_i2c_master #(
        .QUARTER (QUARTER)
    ) u_master (
        .clk     (clk),
        .rst     (rst),
        .go      (m_go),
        .frame   (m_frame),
        .sda_i   (sda_i),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe),
        .done    (m_done),
        .nack    (m_nack),
        .in_cond (m_in_cond)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            base   <= '0;
            step   <= '0;
            last   <= '0;
            done_r <= 1'b0;
            err_r  <= 1'b0;
        end else begin
            done_r <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (|grant) begin
                        base  <= ev_base(ev_sel);
                        last  <= ev_last_step(ev_sel);
                        step  <= '0;
                        state <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (m_done) begin
                        if (m_nack) begin
                            err_r <= 1'b1;
                            state <= SQ_IDLE;
                        end else if (step == last) begin
                            done_r <= 1'b1;
                            state  <= SQ_IDLE;
                        end else begin
                            step  <= step + STEP_W'(1);
                            state <= SQ_ISSUE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign busy     = (state != SQ_IDLE);
    assign done     = done_r;
    assign nack_err = err_r;

endmodule

// File: rtl/evt_i2c_seq_chk.sv
module evt_i2c_seq_chk
    import evtseq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              busy,
    input logic              done,
    input logic              nack_err,
    input logic [NUM_EV-1:0] grant,
    input logic              go,
    input logic [7:0]        ptr_byte,
    input logic              in_cond
);

    // SDA may move under a high SCL only as START or STOP
    assert_sda_cond_R8: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !scl_oe && !$past(scl_oe)) |-> in_cond);

    assert_edge_split_R8: assert property (@(posedge clk) disable iff (rst)
        !(!$stable(scl_oe) && !$stable(sda_oe)));

    assert_line_release_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_oe && !sda_oe));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        nack_err |=> nack_err);

    assert_single_grant_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_no_slew_reg_R9: assert property (@(posedge clk) disable iff (rst)
        go |-> (ptr_byte != REG_SLEW));

endmodule

bind evt_i2c_seq evt_i2c_seq_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .done     (done),
    .nack_err (nack_err),
    .grant    (grant),
    .go       (m_go),
    .ptr_byte (frame_ptr),
    .in_cond  (m_in_cond)
);

// File: tb/evt_i2c_seq_tb_top.sv
module evt_i2c_seq_tb_top;

    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_por = 1'b0;
    logic       ev_detach = 1'b0;
    logic [3:0] ev_contract = 4'h0;
    logic       scl_oe, sda_oe, busy, done, nack_err;
    logic       ack_drv = 1'b0;
    wire        scl_line = ~scl_oe;
    wire        sda_line = ~(sda_oe | ack_drv);

    always #10 clk = ~clk;

    evt_i2c_seq #(.QUARTER(Q)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .ev_por      (ev_por),
        .ev_contract (ev_contract),
        .ev_detach   (ev_detach),
        .sda_i       (sda_line),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe),
        .busy        (busy),
        .done        (done),
        .nack_err    (nack_err)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_cnt = 0;

    always @(negedge clk) begin
        cyc++;
        if (done) done_cnt++;
    end

    // bus target model: captures frames, acknowledges unless told not to
    logic [7:0] fb [64][4];
    int         flen [64];
    int         frame_cnt = 0;
    int         bitk = 0;
    int         bytecnt = 0;
    logic       in_frame = 1'b0;
    logic [7:0] sh = 8'h00;
    int         nack_frame = -1;
    int         nack_byte = -1;
    int         scl_last = 0;
    int         scl_period = 0;

    always @(negedge sda_line) if (scl_line) begin
        in_frame = 1'b1;
        bitk     = 0;
        bytecnt  = 0;
    end

    always @(posedge sda_line) if (scl_line && in_frame) begin
        in_frame = 1'b0;
        if (frame_cnt < 64) flen[frame_cnt] = bytecnt;
        frame_cnt++;
    end

    always @(posedge scl_line) if (in_frame) begin
        if (bitk > 0 && bitk < 8) scl_period = cyc - scl_last;
        scl_last = cyc;
        if (bitk < 8) sh = {sh[6:0], sda_line};
        bitk++;
    end

    always @(negedge scl_line) if (in_frame) begin
        if (bitk == 8) begin
            if (frame_cnt < 64 && bytecnt < 4) fb[frame_cnt][bytecnt] = sh;
            ack_drv = !(frame_cnt == nack_frame && bytecnt == nack_byte);
            bytecnt++;
        end else if (bitk == 9) begin
            ack_drv = 1'b0;
            bitk    = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_code(input int c);
        case (c)
            0: return 16'h00D2;
            1: return 16'h0199;
            2: return 16'h02C5;
            default: return 16'h03BE;
        endcase
    endfunction

    // ev: 0 boot, 1 detach, 2..5 contract 0..3
    task automatic check_evt_frame(input int idx, input int ev, input int stp, input string req);
        logic [7:0] e [4];
        int len;
        e[0] = 8'hE8; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h00;
        if (ev == 0) begin
            len = 3;
            case (stp)
                0: begin e[1] = 8'h00; e[2] = 8'hD2; end
                1: begin e[1] = 8'h04; e[2] = 8'h03; end
                default: begin e[1] = 8'h06; e[2] = 8'hA0; end
            endcase
        end else if (ev == 1) begin
            len = 4; e[2] = 8'hD2; e[3] = 8'h00;
        end else begin
            len = 4;
            e[2] = ref_code(ev - 2)[7:0];
            e[3] = ref_code(ev - 2)[15:8];
        end
        if (idx >= 64) begin
            chk(0, req, "frame index", idx, 63);
            return;
        end
        chk(flen[idx] == len, req, $sformatf("frame %0d length", idx), flen[idx], len);
        for (int i = 0; i < len && i < flen[idx]; i++)
            chk(fb[idx][i] == e[i], req, $sformatf("frame %0d byte %0d", idx, i), fb[idx][i], e[i]);
    endtask

    task automatic fire(input logic [5:0] m);
        @(negedge clk);
        ev_por      = m[0];
        ev_detach   = m[1];
        ev_contract = m[5:2];
        @(negedge clk);
        ev_por      = 1'b0;
        ev_detach   = 1'b0;
        ev_contract = 4'h0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            quiet = busy ? 0 : quiet + 1;
        end
    endtask

    initial begin
        int f0, d0;
        repeat (3) @(negedge clk);
        // reset state R1
        chk(busy == 0, "R1", "busy in reset", busy, 0);
        chk(nack_err == 0, "R1", "nack_err in reset", nack_err, 0);
        chk(scl_oe == 0 && sda_oe == 0, "R1", "lines in reset", {scl_oe, sda_oe}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1, "R7", "busy after reset release", busy, 1);
        wait_idle();
        chk(frame_cnt == 3, "R1", "boot frame count", frame_cnt, 3);
        for (int s = 0; s < 3; s++) check_evt_frame(s, 0, s, "R1 R4");
        chk(done_cnt == 1, "R7", "done after boot", done_cnt, 1);
        chk(scl_period == 4 * Q, "R8", "SCL period cycles", scl_period, 4 * Q);

        // sweep every non-boot event alone, with busy timing R7
        for (int ev = 1; ev < 6; ev++) begin
            f0 = frame_cnt; d0 = done_cnt;
            @(negedge clk);
            chk(busy == 0, "R7", "idle before strobe", busy, 0);
            ev_detach   = (ev == 1);
            ev_contract = (ev >= 2) ? 4'(1 << (ev - 2)) : 4'h0;
            @(negedge clk);
            chk(busy == 1, "R7", $sformatf("busy after strobe ev%0d", ev), busy, 1);
            ev_detach = 1'b0; ev_contract = 4'h0;
            wait_idle();
            chk(frame_cnt == f0 + 1, (ev == 1) ? "R3" : "R2", "frame count", frame_cnt - f0, 1);
            check_evt_frame(f0, ev, 0, (ev == 1) ? "R3" : "R2");
            chk(done_cnt == d0 + 1, "R7", "done pulses", done_cnt - d0, 1);
        end

        // boot list on request R1
        f0 = frame_cnt;
        fire(6'b000001);
        wait_idle();
        chk(frame_cnt == f0 + 3, "R1", "rerun boot count", frame_cnt - f0, 3);
        for (int s = 0; s < 3; s++) check_evt_frame(f0 + s, 0, s, "R1");

        // priority and merging R5 R10
        f0 = frame_cnt;
        fire(6'b100000);            // contract 3 starts
        fire(6'b001000);            // contract 1 pending
        fire(6'b000010);            // detach pending
        fire(6'b000100);            // contract 0 pending
        fire(6'b001000);            // contract 1 again, merged
        wait_idle();
        chk(frame_cnt == f0 + 4, "R10", "merged frame count", frame_cnt - f0, 4);
        check_evt_frame(f0,     5, 0, "R5");
        check_evt_frame(f0 + 1, 1, 0, "R5");
        check_evt_frame(f0 + 2, 2, 0, "R5");
        check_evt_frame(f0 + 3, 3, 0, "R5");

        f0 = frame_cnt;
        fire(6'b010000);            // contract 2 starts
        fire(6'b100001);            // boot and contract 3 together
        wait_idle();
        chk(frame_cnt == f0 + 5, "R5", "boot priority count", frame_cnt - f0, 5);
        check_evt_frame(f0, 4, 0, "R5");
        for (int s = 0; s < 3; s++) check_evt_frame(f0 + 1 + s, 0, s, "R5");
        check_evt_frame(f0 + 4, 5, 0, "R5");

        // NACK on the address byte R6
        chk(nack_err == 0, "R6", "no error yet", nack_err, 0);
        f0 = frame_cnt; d0 = done_cnt;
        nack_frame = frame_cnt; nack_byte = 0;
        fire(6'b001000);
        wait_idle();
        chk(frame_cnt == f0 + 1, "R6", "aborted frame count", frame_cnt - f0, 1);
        chk(flen[f0] == 1, "R6", "bytes before abort", flen[f0], 1);
        chk(nack_err == 1, "R6", "error set", nack_err, 1);
        chk(done_cnt == d0, "R6", "no done on abort", done_cnt - d0, 0);

        // NACK on data inside the boot list with detach waiting R6
        f0 = frame_cnt; d0 = done_cnt;
        nack_frame = frame_cnt + 1; nack_byte = 2;
        fire(6'b000011);
        wait_idle();
        chk(frame_cnt == f0 + 3, "R6", "frames after data nack", frame_cnt - f0, 3);
        check_evt_frame(f0, 0, 0, "R6");
        chk(flen[f0 + 1] == 3, "R6", "nacked frame length", flen[f0 + 1], 3);
        check_evt_frame(f0 + 2, 1, 0, "R6");
        chk(done_cnt == d0 + 1, "R6", "done only for detach", done_cnt - d0, 1);
        nack_frame = -1; nack_byte = -1;

        f0 = frame_cnt;
        fire(6'b010000);
        wait_idle();
        check_evt_frame(f0, 4, 0, "R6");
        chk(nack_err == 1, "R6", "error sticky", nack_err, 1);

        // slew register never addressed R9
        begin
            int bad = 0;
            for (int i = 0; i < frame_cnt && i < 64; i++)
                if (flen[i] >= 2 && fb[i][1] == 8'h03) bad++;
            chk(bad == 0, "R9", "frames pointing at 0x03", bad, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors + 0);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 watchdog actual=busy expected=idle");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule